// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block derives the bit clock of an SPI master from the system clock. The clock passes through two divide stages in series. The first stage is a prescaler that accepts only even ratios. The second stage is a rate counter that divides the prescaler's output by one plus an 8-bit rate value. The overall ratio is the product of the two. Because that product is always even, the serial clock always has equal high and low phases.

The controlling logic writes the prescale, rate and polarity inputs while the enable is low; the block takes these values in only during that time. It then raises the enable. While enabled, the block produces the serial clock. It also marks each move away from the idle level with a one-cycle leading strobe and each return to the idle level with a one-cycle trailing strobe. A prescale setting with no usable even part cannot divide anything. For such a setting the block raises an error flag and keeps the clock quiet.

Top module: `spi_sclk_gen`

## Requirements
- R1: One full serial clock period lasts P × (1 + S) system clocks. P is the effective prescale and S is the rate value (0 to 255). For example, at 80 MHz, prescale 2/rate 1 and prescale 4/rate 0 both give 20 MHz, prescale 2/rate 9 gives 4 MHz, prescale 2/rate 3 gives 10 MHz and prescale 4/rate 19 gives 1 MHz.
- R2: The effective prescale is the 8-bit prescale input with bit 0 forced to zero, so written values 5 and 4 divide identically.
- R3: When the effective prescale is 0 (written 0 or 1), cfg_err_o is high, sclk_o stays at the idle level while enabled, and neither strobe fires. For every other prescale, cfg_err_o is low.
- R4: The high and low phases of sclk_o are equal. Each lasts (P/2) × (1 + S) system clocks.
- R5: While en_i is low, sclk_o equals cpol_i one clock later and both strobes are low.
- R6: After en_i rises, the first change of sclk_o follows the H-th rising clock edge at which en_i is high, where H is the half period of R4.
- R7: lead_o is high for exactly one clock, in the same cycle that sclk_o leaves the idle level. trail_o is high for exactly one clock, in the same cycle that sclk_o returns to the idle level. The two are never high together.
- R8: The prescale, rate and polarity inputs are captured only on clock edges where en_i is low. Changes made while en_i is high have no effect until the next disabled period.
- R9: After reset, sclk_o, lead_o, trail_o and cfg_err_o are all low. The held configuration resets to prescale 2, rate 0, polarity 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run the divider; low holds the clock idle and opens the configuration hold |
| prescale_i | input | 8 | Prescale ratio; bit 0 ignored |
| rate_i | input | 8 | Rate value S; second stage divides by S + 1 |
| cpol_i | input | 1 | Idle level of the serial clock |
| sclk_o | output | 1 | Serial bit clock |
| lead_o | output | 1 | One-cycle strobe when sclk_o leaves idle |
| trail_o | output | 1 | One-cycle strobe when sclk_o returns to idle |
| cfg_err_o | output | 1 | Held prescale has no usable even part |

## Verification
Suppose a counter holds a wrong terminal value, or one stage misses a tick. The next sclk_o change then lands on the wrong cycle. This shows up one half period after enable, as a gap that does not match the expected count. A held configuration that leaks while enabled changes the gap between two consecutive edges in the same burst. A wrong idle-level register gives a strobe of the wrong kind on the very first edge, or a wrong resting level one clock after enable drops.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE  = 2'd0,
    EDGE_LEAD  = 2'd1,
    EDGE_TRAIL = 2'd2
  } edge_kind_e;

  // Decide which strobe a toggle produces, given the current level and idle level.
  function automatic edge_kind_e next_edge_kind(input logic level, input logic idle);
    return (level == idle) ? EDGE_LEAD : EDGE_TRAIL;
  endfunction

  // Cycles spent in one phase of the serial clock (for reference arithmetic).
  function automatic int unsigned half_cycles(input int unsigned pre, input int unsigned rate);
    return (pre / 2) * (rate + 1);
  endfunction

endpackage

// File: rtl/sclk_cfg_hold.sv
module sclk_cfg_hold #(
  parameter int PRE_W  = 8,
  parameter int RATE_W = 8,
  localparam int HALF_W = PRE_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [PRE_W-1:0]  pre_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              cpol_i,
  output logic [HALF_W-1:0] pre_half_o,
  output logic [RATE_W-1:0] rate_o,
  output logic              cpol_o,
  output logic              err_o
);
  logic [PRE_W-1:0]  pre_q;
  logic [RATE_W-1:0] rate_q;
  logic              cpol_q;

  // Config is taken in only while the divider is stopped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= PRE_W'(2);
      rate_q <= '0;
      cpol_q <= 1'b0;
    end else if (!en_i) begin
      pre_q  <= pre_i;
      rate_q <= rate_i;
      cpol_q <= cpol_i;
    end
  end

  // Dropping bit 0 and halving: the prescale stage counts half the even ratio.
  assign pre_half_o = pre_q[PRE_W-1:1];
  assign rate_o     = rate_q;
  assign cpol_o     = cpol_q;
  assign err_o      = (pre_half_o == '0);

  logic unused_lsb;
  assign unused_lsb = pre_q[0];
endmodule

// File: rtl/sclk_div_stage.sv
module sclk_div_stage #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          step_i,
  input  logic [CW-1:0] limit_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;
  logic          at_limit;

  assign at_limit = (cnt_q == limit_i);
  assign done_o   = run_i && step_i && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= at_limit ? '0 : cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/sclk_edge_out.sv
module sclk_edge_out
  import spi_sclk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic toggle_i,
  input  logic idle_next_i,
  input  logic idle_held_i,
  output logic sclk_o,
  output logic lead_o,
  output logic trail_o
);
  logic       sclk_q;
  edge_kind_e kind_w;

  assign kind_w = next_edge_kind(sclk_q, idle_held_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end else if (!en_i) begin
      sclk_q  <= idle_next_i;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end else if (toggle_i) begin
      sclk_q  <= ~sclk_q;
      lead_o  <= (kind_w == EDGE_LEAD);
      trail_o <= (kind_w == EDGE_TRAIL);
    end else begin
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end
  end

  assign sclk_o = sclk_q;
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
  parameter int PRE_W  = 8,
  parameter int RATE_W = 8,
  localparam int HALF_W = PRE_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [PRE_W-1:0]  prescale_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              cpol_i,
  output logic              sclk_o,
  output logic              lead_o,
  output logic              trail_o,
  output logic              cfg_err_o
);
  logic [HALF_W-1:0] pre_half_w;
  logic [RATE_W-1:0] rate_w;
  logic              cpol_q;
  logic              run_w;
  logic              tick_w;
  logic              toggle_w;

  sclk_cfg_hold #(.PRE_W(PRE_W), .RATE_W(RATE_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_i),
    .pre_i(prescale_i), .rate_i(rate_i), .cpol_i(cpol_i),
    .pre_half_o(pre_half_w), .rate_o(rate_w), .cpol_o(cpol_q), .err_o(cfg_err_o)
  );

  assign run_w = en_i && !cfg_err_o;

  // First stage: one tick every P/2 system clocks.
  sclk_div_stage #(.CW(HALF_W)) pre_stage_i (
    .clk(clk), .rst_n(rst_n), .run_i(run_w), .step_i(1'b1),
    .limit_i(pre_half_w - HALF_W'(1)), .done_o(tick_w)
  );

  // Second stage: toggle every (S + 1) ticks.
  sclk_div_stage #(.CW(RATE_W)) rate_stage_i (
    .clk(clk), .rst_n(rst_n), .run_i(run_w), .step_i(tick_w),
    .limit_i(rate_w), .done_o(toggle_w)
  );

  sclk_edge_out edge_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .toggle_i(toggle_w),
    .idle_next_i(cpol_i), .idle_held_i(cpol_q),
    .sclk_o(sclk_o), .lead_o(lead_o), .trail_o(trail_o)
  );
endmodule

// File: rtl/spi_sclk_gen_chk.sv
module spi_sclk_gen_chk #(
  parameter int PRE_W  = 8,
  parameter int RATE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_i,
  input logic              cpol_i,
  input logic              cpol_q,
  input logic              sclk_o,
  input logic              lead_o,
  input logic              trail_o,
  input logic              cfg_err_o,
  input logic              toggle_w,
  input logic [PRE_W-2:0]  pre_half_w,
  input logic [RATE_W-1:0] rate_w
);
  p_idle_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (sclk_o == $past(cpol_i)) && !lead_o && !trail_o);

  p_err_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err_o && en_i) |=> $stable(sclk_o) && !lead_o && !trail_o);

  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lead_o, trail_o}));

  p_strobe_on_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_o || trail_o) |-> (sclk_o != $past(sclk_o)));

  p_lead_leaves_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lead_o |-> (sclk_o != cpol_q));

  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && $past(en_i)) |-> $stable(pre_half_w) && $stable(rate_w));

  p_edge_from_counter_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_i) && (sclk_o != $past(sclk_o))) |-> $past(toggle_w));
endmodule

bind spi_sclk_gen spi_sclk_gen_chk #(.PRE_W(PRE_W), .RATE_W(RATE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .cpol_i(cpol_i), .cpol_q(cpol_q),
  .sclk_o(sclk_o), .lead_o(lead_o), .trail_o(trail_o), .cfg_err_o(cfg_err_o),
  .toggle_w(toggle_w), .pre_half_w(pre_half_w), .rate_w(rate_w)
);

// File: tb/spi_sclk_gen_tb_top.sv
module spi_sclk_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [7:0] pre;
  logic [7:0] rate;
  logic       cpol;
  wire        sclk, lead, trail, err;

  always #5 clk = ~clk;

  spi_sclk_gen dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .prescale_i(pre), .rate_i(rate),
    .cpol_i(cpol), .sclk_o(sclk), .lead_o(lead), .trail_o(trail), .cfg_err_o(err)
  );

  typedef struct {
    int    gap;
    bit    lead;
    string req;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  int   gap   = 0;
  logic prev_sclk = 1'b0;
  bit   mon_on = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: scoreboard pop and compare on every serial clock change.
  always @(negedge clk) begin
    exp_t e;
    if (mon_on) begin
      if (en) begin
        gap++;
        if (sclk !== prev_sclk) begin
          if (q.size() == 0) begin
            check(1'b0, "R3", "unexpected sclk edge", 1, 0);
          end else begin
            e = q.pop_front();
            check(gap == e.gap, e.req, "half period (R4/R6)", gap, e.gap);
            check(lead == e.lead && trail == !e.lead, "R7", "strobe kind",
                  int'({lead, trail}), e.lead ? 2 : 1);
          end
          gap = 0;
        end else if (lead || trail) begin
          check(1'b0, "R7", "strobe without edge", int'({lead, trail}), 0);
        end
      end else begin
        gap = 0;
        if (lead || trail) check(1'b0, "R5", "strobe while disabled", int'({lead, trail}), 0);
      end
      prev_sclk = sclk;
    end
  end

  task automatic burst(input logic [7:0] p, input logic [7:0] r, input logic c,
                       input int n, input string req, input bit chg);
    int h;
    @(negedge clk);
    en   <= 1'b0;
    pre  <= p;
    rate <= r;
    cpol <= c;
    repeat (3) @(negedge clk);
    check(err == 1'b0, "R3", "error flag on valid prescale", err, 0);
    check(sclk == c, "R5", "idle level before run", sclk, c);
    h = (int'(p & 8'hFE) * (int'(r) + 1)) / 2;
    for (int i = 0; i < n; i++) q.push_back('{gap: h, lead: (i % 2 == 0), req: req});
    en <= 1'b1;
    if (chg) begin
      @(negedge clk);
      pre  <= p + 8'd6;
      rate <= r + 8'd3;
      cpol <= ~c;
      repeat (n * h - 1) @(negedge clk);
    end else begin
      repeat (n * h) @(negedge clk);
    end
    en <= 1'b0;
    repeat (2) @(negedge clk);
    check(q.size() == 0, req, "edges outstanding", q.size(), 0);
    if (!chg) check(sclk == c, "R5", "idle level after stop", sclk, c);
  endtask

  task automatic err_case(input logic [7:0] p, input logic c);
    @(negedge clk);
    en   <= 1'b0;
    pre  <= p;
    cpol <= c;
    repeat (3) @(negedge clk);
    check(err == 1'b1, "R3", "error flag on empty prescale", err, 1);
    en <= 1'b1;
    repeat (40) @(negedge clk);
    check(sclk == c, "R3", "clock held idle on error", sclk, c);
    check(err == 1'b1, "R3", "error flag while enabled", err, 1);
    en <= 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    en    = 1'b0;
    pre   = 8'd2;
    rate  = 8'd0;
    cpol  = 1'b0;
    repeat (4) @(negedge clk);
    check(sclk == 1'b0, "R9", "sclk in reset", sclk, 0);
    check(err == 1'b0, "R9", "error flag in reset", err, 0);
    rst_n <= 1'b1;
    @(negedge clk);
    check({lead, trail} == 2'b00, "R9", "strobes after reset", int'({lead, trail}), 0);
    prev_sclk = sclk;
    mon_on = 1'b1;

    burst(8'd2,   8'd1,  1'b0, 6, "R1", 1'b0); // 20 MHz at 80 MHz
    burst(8'd4,   8'd0,  1'b0, 6, "R1", 1'b0); // 20 MHz
    burst(8'd2,   8'd9,  1'b0, 4, "R1", 1'b0); // 4 MHz
    burst(8'd2,   8'd3,  1'b1, 4, "R5", 1'b0); // 10 MHz, idle high
    burst(8'd4,   8'd19, 1'b0, 2, "R1", 1'b0); // 1 MHz
    burst(8'd2,   8'd0,  1'b0, 6, "R6", 1'b0); // shortest half period
    burst(8'd5,   8'd2,  1'b0, 4, "R2", 1'b0); // odd prescale behaves as 4
    burst(8'd3,   8'd1,  1'b1, 4, "R2", 1'b0); // odd prescale behaves as 2
    burst(8'd6,   8'd2,  1'b0, 4, "R8", 1'b1); // inputs changed mid-run
    err_case(8'd1, 1'b0);
    err_case(8'd0, 1'b1);
    burst(8'd254, 8'd40, 1'b1, 2, "R4", 1'b0); // widest prescale
    burst(8'd10,  8'd4,  1'b1, 4, "R7", 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule